// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counter Timer

This block is a register-mapped timer with two independent down-counting channels. Each channel holds a 24-bit initial value, a running count and a control word. The control word carries a run enable, an interrupt enable, a mode select for periodic or single-shot operation, and an 8-bit prescale. With prescale P, the counter steps once every P+1 clock cycles. A single status register is shared by both channels and holds one expiry flag per channel. Software clears a flag by writing a one to its bit. The interrupt line is high while any flagged channel also has its interrupt enabled.

Software reaches the registers through a simple port with separate write and read strobes. A write lands on the clock edge where `wrEn` is high. A read returns its data on `rdData` one clock after `rdEn` is sampled. Both counts can be read while the channels run, so one channel can serve as a free-running time base while the other generates event interrupts.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: Registers are byte-addressed. Control k is at 0x00+4k, initial count k at 0x08+4k, current count k at 0x10+4k and status at 0x18. Any other offset reads as zero. `rdData` carries the register value from the clock edge at which `rdEn` is sampled, and that edge's own updates are not included.
- R3: In a control word, bit 30 is run enable, bit 29 is interrupt enable, bit 27 selects periodic mode (1) or single-shot mode (0), and bits 7:0 hold the prescale. All other bits read as zero and ignore writes.
- R4: An initial count register keeps only bits 23:0 of the written data. The counter decrements toward zero.
- R5: With prescale P, a running counter decrements once every P+1 clocks. Counting starts on the edge after the load, so a load of N expires exactly N*(P+1) clocks after the enabling write.
- R6: A control write with bit 30 set loads the count from the initial count register and restarts the prescaler from zero. The next read shows the loaded value.
- R7: In single-shot mode, expiry leaves the count at zero and clears the run enable bit. The count then stays at zero.
- R8: In periodic mode, expiry reloads the count from the initial count register, and counting continues with the run enable still set.
- R9: A channel's status bit (bit 0 for channel 0, bit 1 for channel 1) sets on the tick where its count goes from 1 to 0. This happens whether or not its interrupt is enabled.
- R10: Writing status with bit k set clears flag k. Writing 0x1F clears all flags.
- R11: `irq` is high exactly when some channel has its status flag set and its interrupt enable set.
- R12: Writing zero to a control register stops the channel. In the cycle of any control write, that write takes precedence over counting, and the count freezes at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Read data, valid one clock after `rdEn` |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that a control write and that channel's expiry tick never coincide in a way that hides the expiry. They also assume that the initial count does not change in the cycle a periodic reload consumes it. The stimulus stops or reprograms a channel only while that channel is idle or far from expiry. It writes an initial count only before the enabling control write, never while that count could be reloaded. All register accesses are driven on the falling edge, so each strobe is stable through the sampling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH  = 2;
  localparam int CNT_W   = 24;
  localparam int PSC_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int EN_BIT  = 30;
  localparam int IE_BIT  = 29;
  localparam int PER_BIT = 27;
  localparam int STRIDE  = 4;
  localparam int CTRL_BASE = 'h00;
  localparam int INIT_BASE = 'h08;
  localparam int CNT_BASE  = 'h10;
  localparam int STAT_OFF  = 'h18;

  typedef struct packed {
    logic             en;
    logic             ie;
    logic             periodic;
    logic [PSC_W-1:0] psc;
  } chanCfg_t;

  // strobes from register control to a counter datapath
  typedef struct packed {
    logic load;    // restart from initial value
    logic freeze;  // control write this cycle: no counting
  } chanStrb_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int cntW = CNT_W,
  parameter int pscW = PSC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            periodic,
  input  logic [pscW-1:0] psc,
  input  logic [cntW-1:0] initVal,
  input  chanStrb_t       strb,
  output logic [cntW-1:0] count,
  output logic            expire
);
  logic [pscW-1:0] pscCnt;
  logic            tick;
  logic            atEnd;

  always_comb begin
    tick   = run && !strb.freeze && (pscCnt == psc);
    atEnd  = (count <= cntW'(1));
    expire = tick && atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      pscCnt <= '0;
    end else if (strb.load) begin
      count  <= initVal;
      pscCnt <= '0;
    end else if (run && !strb.freeze) begin
      if (tick) begin
        pscCnt <= '0;
        if (atEnd) count <= periodic ? initVal : '0;
        else       count <= count - cntW'(1);
      end else begin
        pscCnt <= pscCnt + pscW'(1);
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            rdAddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] count,
  input  logic [NUM_CH-1:0]            expire,
  output chanCfg_t [NUM_CH-1:0]        cfg,
  output logic [NUM_CH-1:0][CNT_W-1:0] initVal,
  output chanStrb_t [NUM_CH-1:0]       strb,
  output logic [NUM_CH-1:0]            stat,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irq
);
  logic [NUM_CH-1:0] ctrlWr, initWr, ieVec;
  logic              statWr;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWr;

  function automatic logic [DATA_W-1:0] cfgWord(chanCfg_t c);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[EN_BIT]  = c.en;
    w[IE_BIT]  = c.ie;
    w[PER_BIT] = c.periodic;
    w[PSC_W-1:0] = c.psc;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] offs(int base, int k);
    return ADDR_W'(base + STRIDE * k);
  endfunction

  always_comb begin
    statWr   = wrEn && (wrAddr == ADDR_W'(STAT_OFF));
    unusedWr = ^wrData;
    for (int k = 0; k < NUM_CH; k++) begin
      ctrlWr[k]       = wrEn && (wrAddr == offs(CTRL_BASE, k));
      initWr[k]       = wrEn && (wrAddr == offs(INIT_BASE, k));
      strb[k].freeze  = ctrlWr[k];
      strb[k].load    = ctrlWr[k] && wrData[EN_BIT];
      ieVec[k]        = cfg[k].ie;
    end
    irq = |(stat & ieVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      initVal <= '0;
      stat    <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (ctrlWr[k]) begin
          cfg[k].en       <= wrData[EN_BIT];
          cfg[k].ie       <= wrData[IE_BIT];
          cfg[k].periodic <= wrData[PER_BIT];
          cfg[k].psc      <= wrData[PSC_W-1:0];
        end else if (expire[k] && !cfg[k].periodic) begin
          cfg[k].en <= 1'b0;
        end
        if (initWr[k]) initVal[k] <= wrData[CNT_W-1:0];
        if (expire[k])                  stat[k] <= 1'b1;
        else if (statWr && wrData[k])   stat[k] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rdAddr == offs(CTRL_BASE, k)) rdNext = cfgWord(cfg[k]);
      if (rdAddr == offs(INIT_BASE, k)) rdNext = DATA_W'(initVal[k]);
      if (rdAddr == offs(CNT_BASE, k))  rdNext = DATA_W'(count[k]);
    end
    if (rdAddr == ADDR_W'(STAT_OFF)) rdNext = DATA_W'(stat);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  chanCfg_t  [NUM_CH-1:0]            cfg;
  chanStrb_t [NUM_CH-1:0]            strb;
  logic      [NUM_CH-1:0][CNT_W-1:0] initVal;
  logic      [NUM_CH-1:0][CNT_W-1:0] count;
  logic      [NUM_CH-1:0]            expire;
  logic      [NUM_CH-1:0]            stat;

  tmr_regs u_regs (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .count(count), .expire(expire),
    .cfg(cfg), .initVal(initVal), .strb(strb), .stat(stat),
    .rdData(rdData), .irq(irq)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    tmr_chan #(.cntW(CNT_W), .pscW(PSC_W)) u_chan (
      .clk(clk), .rstN(rstN),
      .run(cfg[k].en), .periodic(cfg[k].periodic), .psc(cfg[k].psc),
      .initVal(initVal[k]), .strb(strb[k]),
      .count(count[k]), .expire(expire[k])
    );
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input chanCfg_t  [NUM_CH-1:0]       cfg,
  input chanStrb_t [NUM_CH-1:0]       strb,
  input logic [NUM_CH-1:0][CNT_W-1:0] count,
  input logic [NUM_CH-1:0][CNT_W-1:0] initVal,
  input logic [NUM_CH-1:0]            expire,
  input logic [NUM_CH-1:0]            stat
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
      (expire[k] && !cfg[k].periodic && !strb[k].freeze) |=> !cfg[k].en && (count[k] == '0));

    a_r8_periodic_reload: assert property (@(posedge clk) disable iff (!rstN)
      (expire[k] && cfg[k].periodic && !strb[k].freeze)
        |=> cfg[k].en && (count[k] == $past(initVal[k])));

    a_r9_flag_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
      expire[k] |=> stat[k]);

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      ((!cfg[k].en || strb[k].freeze) && !strb[k].load) |=> $stable(count[k]));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
      (cfg[k].en && !strb[k].freeze && !expire[k])
        |=> (count[k] == $past(count[k])) || (count[k] == $past(count[k]) - 1'b1));
  end
endmodule

bind twin_timer tmr_checker u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb),
  .count(count), .initVal(initVal), .expire(expire), .stat(stat)
);

// File: tb/sim_twin_timer.sv
module sim_twin_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  twin_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: issue a read and queue what it must return
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rdEn = 1'b1; rdAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    #1;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
    end
  endtask

  // monitor: compare returned read data against the queue
  initial forever begin
    @(posedge clk);
    if (rdEn) begin
      @(negedge clk);
      #1;
      begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s read actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    chkIrq(1'b0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'h18, 32'h0, "R1");
    // R3 reserved bits, R12 zero write
    wr(8'h04, 32'h9400_00FF);
    rd(8'h04, 32'h0000_00FF, "R3");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R12");
    // R4 width, R2 unmapped
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h00FF_FFFF, "R4");
    rd(8'h1C, 32'h0, "R2");
    // single-shot on channel 0, prescale 0, load 5
    wr(8'h08, 32'd5);
    wr(8'h00, 32'h6000_0000);
    rd(8'h10, 32'd5, "R6");
    idle(3);
    chkIrq(1'b0, "R5");
    idle(1);
    chkIrq(1'b1, "R11");
    rd(8'h00, 32'h2000_0000, "R7");
    rd(8'h10, 32'd0, "R7");
    rd(8'h18, 32'h1, "R9");
    idle(3);
    rd(8'h10, 32'd0, "R7");
    wr(8'h18, 32'h1);
    chkIrq(1'b0, "R10");
    rd(8'h18, 32'h0, "R10");
    // periodic on channel 1, prescale 2, load 3 -> 9 clocks per period
    wr(8'h0C, 32'd3);
    wr(8'h04, 32'h6800_0002);
    idle(8);
    chkIrq(1'b0, "R5");
    idle(1);
    chkIrq(1'b1, "R8");
    rd(8'h18, 32'h2, "R9");
    wr(8'h18, 32'h2);
    chkIrq(1'b0, "R10");
    idle(6);
    chkIrq(1'b0, "R8");
    idle(1);
    chkIrq(1'b1, "R8");
    rd(8'h04, 32'h6800_0002, "R8");
    wr(8'h04, 32'h0);
    wr(8'h18, 32'h1F);
    rd(8'h18, 32'h0, "R10");
    chkIrq(1'b0, "R10");
    // interrupt disabled: flag still sets, irq stays low
    wr(8'h08, 32'd2);
    wr(8'h00, 32'h4000_0000);
    idle(3);
    chkIrq(1'b0, "R11");
    rd(8'h18, 32'h1, "R9");
    wr(8'h18, 32'h1F);
    rd(8'h18, 32'h0, "R10");
    // count readable while running
    wr(8'h0C, 32'd100);
    wr(8'h04, 32'h4800_0000);
    rd(8'h14, 32'd100, "R6");
    idle(4);
    rd(8'h14, 32'd95, "R2");
    // fresh countdown from a new value
    wr(8'h0C, 32'd50);
    wr(8'h04, 32'h4800_0000);
    rd(8'h14, 32'd50, "R6");
    // stop: control write freezes the count in its own cycle
    wr(8'h04, 32'h0);
    rd(8'h14, 32'd49, "R12");
    idle(4);
    rd(8'h14, 32'd49, "R12");
    rd(8'h04, 32'h0, "R12");
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule